// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept or dropped. A receive path streams the frame to it one byte per cycle. A start strobe opens the frame, a byte-valid qualifier carries each byte, and an end strobe closes it. The block compares the first six bytes, which are the destination address, against a programmed station address and against the all-ones broadcast address. It also counts the frame length. One cycle after the end strobe it produces a single decision pulse, which says accept or reject.

The block holds six 16-bit configuration registers, written through a small select/data port:

| Select code | Register |
|---|---|
| 0 | filter-control |
| 1 | MAC-configuration |
| 2 | command |
| 4 | station word 0 |
| 5 | station word 1 |
| 6 | station word 2 |

A frame is accepted only when all three of these hold:
- receive is enabled in both the command and the MAC-configuration registers;
- the frame is long enough, or short frames are allowed;
- the address passes the filter, or the pass-all override is set.

Top module: `rx_addr_filter`

## Requirements
- R1: Station address byte k, where byte 0 is the first byte on the wire, is packed as follows. Bytes 0 and 1 are in station word 2 (select 6), bytes 2 and 3 in word 1 (select 5), and bytes 4 and 5 in word 0 (select 4). In each word the lower-numbered byte is in bits 7:0 and the other byte in bits 15:8.
- R2: When filter-control bit 5 is set, a frame whose six destination bytes all equal the station address passes the address filter. A frame that differs in any one byte does not pass on this rule.
- R3: When filter-control bit 1 is set, a frame whose 48 destination bits are all one passes the address filter. With bit 1 clear, such a frame does not pass on this rule.
- R4: When MAC-configuration bit 1 is set, every frame passes the address filter whatever its destination and the filter-control bits.
- R5: A frame that matches neither enabled rule is rejected. A frame with fewer than six bytes never passes the address filter except through R4.
- R6: A frame with fewer than MIN_FRAME bytes is rejected unless command bit 6 is set. A frame of exactly MIN_FRAME bytes is not short.
- R7: A frame is accepted only if command bit 0 and MAC-configuration bit 0 are both set when the frame ends.
- R8: A start strobe restarts the byte count and the address comparison. The bytes of a frame that was cut off without an end strobe do not affect the next frame, and such a frame produces no decision.
- R9: Each end strobe produces a decision-valid pulse exactly one cycle long, in the next cycle. The accept output is high only together with decision-valid. Both outputs are low after reset.
- R10: The byte count saturates at its maximum. A frame longer than the counter range is never treated as short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Register select code |
| cfgWrData | input | 16 | Configuration write data |
| frmStart | input | 1 | Start-of-frame strobe, on a cycle with no byte |
| byteValid | input | 1 | Qualifies byteData |
| byteData | input | 8 | Frame byte, first destination byte first |
| frmEnd | input | 1 | End-of-frame strobe, on a cycle with no byte |
| decValid | output | 1 | One-cycle decision pulse |
| decAccept | output | 1 | Frame accepted, valid with decValid |

## Verification
The bench builds the filter with MIN_FRAME set to 16 and a 6-bit byte counter. A short-frame threshold of 16 keeps runt frames, the exact threshold length and frames one byte below it inexpensive to send. A 6-bit counter saturates at 63, so a 70-byte frame tests saturation. A counter that wrapped instead would read that frame as 6 bytes long and reject it as short. The parameter values do not affect address packing or broadcast behaviour, because those are fixed at six bytes.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  localparam int ADDR_BYTES = 6;

  // register select codes on the configuration port
  typedef enum logic [2:0] {
    SEL_FILT = 3'd0,
    SEL_MAC  = 3'd1,
    SEL_CMD  = 3'd2,
    SEL_STA0 = 3'd4,
    SEL_STA1 = 3'd5,
    SEL_STA2 = 3'd6
  } cfgSel_e;

  // bit positions inside the control registers
  localparam int FILT_BCAST_BIT  = 1;
  localparam int FILT_PERF_BIT   = 5;
  localparam int MAC_RXEN_BIT    = 0;
  localparam int MAC_PASSALL_BIT = 1;
  localparam int CMD_RXEN_BIT    = 0;
  localparam int CMD_RUNT_BIT    = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrFlags;
    logic       cmpEn;
    logic [2:0] cmpIdx;
    logic       decide;
    logic       isShort;
    logic       addrFull;
  } ctrlStrb_t;

endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int CNT_W     = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frmStart,
  input  logic      byteValid,
  input  logic      frmEnd,
  output ctrlStrb_t strb
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] ADDR_C   = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] byteCnt;

  // byte counter: cleared at start, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (frmStart) begin
      byteCnt <= '0;
    end else if (byteValid && (byteCnt != CNT_MAX)) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.clrFlags = frmStart;
    strb.cmpEn    = byteValid && !frmStart && (byteCnt < ADDR_C);
    strb.cmpIdx   = byteCnt[2:0];
    strb.decide   = frmEnd && !frmStart;
    strb.isShort  = byteCnt < MIN_C;
    strb.addrFull = byteCnt >= ADDR_C;
  end

  // R8: start strobe restarts the count
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    frmStart |=> (byteCnt == '0));

  // R10: counter holds at its maximum
  assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_MAX && byteValid && !frmStart) |=> (byteCnt == CNT_MAX));

endmodule

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgSel,
  input  logic [15:0] cfgWrData,
  input  logic [7:0]  byteData,
  input  ctrlStrb_t   strb,
  output logic        decValid,
  output logic        decAccept
);

  logic [15:0] staReg [3];
  logic [15:0] filtReg;
  logic [15:0] macReg;
  logic [15:0] cmdReg;
  logic [7:0]  staBytes [8];
  logic        matchFlag;
  logic        bcastFlag;
  logic        rxOn;
  logic        lenOk;
  logic        addrOk;
  logic        acceptNow;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staReg[0] <= '0;
      staReg[1] <= '0;
      staReg[2] <= '0;
      filtReg   <= '0;
      macReg    <= '0;
      cmdReg    <= '0;
    end else if (cfgWrEn) begin
      case (cfgSel_e'(cfgSel))
        SEL_FILT: filtReg   <= cfgWrData;
        SEL_MAC:  macReg    <= cfgWrData;
        SEL_CMD:  cmdReg    <= cfgWrData;
        SEL_STA0: staReg[0] <= cfgWrData;
        SEL_STA1: staReg[1] <= cfgWrData;
        SEL_STA2: staReg[2] <= cfgWrData;
        default: ;
      endcase
    end
  end

  // station byte k lives in word 2-k/2, low half for even k
  for (genvar g = 0; g < 8; g++) begin : g_staByte
    if (g < ADDR_BYTES) begin : g_real
      assign staBytes[g] = staReg[2 - g/2][8*(g%2) +: 8];
    end else begin : g_pad
      assign staBytes[g] = 8'h00;
    end
  end

  // running comparison flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      bcastFlag <= 1'b0;
    end else if (strb.clrFlags) begin
      matchFlag <= 1'b1;
      bcastFlag <= 1'b1;
    end else if (strb.cmpEn) begin
      matchFlag <= matchFlag && (byteData == staBytes[strb.cmpIdx]);
      bcastFlag <= bcastFlag && (byteData == 8'hFF);
    end
  end

  always_comb begin
    rxOn   = cmdReg[CMD_RXEN_BIT] && macReg[MAC_RXEN_BIT];
    lenOk  = !strb.isShort || cmdReg[CMD_RUNT_BIT];
    addrOk = macReg[MAC_PASSALL_BIT] ||
             (strb.addrFull &&
              ((filtReg[FILT_PERF_BIT]  && matchFlag) ||
               (filtReg[FILT_BCAST_BIT] && bcastFlag)));
    acceptNow = rxOn && lenOk && addrOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= strb.decide;
      decAccept <= strb.decide && acceptNow;
    end
  end

  // R7: acceptance needs both receive enables
  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> $past(cmdReg[CMD_RXEN_BIT] && macReg[MAC_RXEN_BIT]));

  // R6: a short frame is accepted only with runt pass
  assert_runt_R6: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> ($past(!strb.isShort) || $past(cmdReg[CMD_RUNT_BIT])));

  // R5: without pass-all the address must be complete
  assert_addr_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decAccept && !$past(macReg[MAC_PASSALL_BIT])) |-> $past(strb.addrFull));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int CNT_W     = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgSel,
  input  logic [15:0] cfgWrData,
  input  logic        frmStart,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        frmEnd,
  output logic        decValid,
  output logic        decAccept
);

  ctrlStrb_t strb;

  rx_addr_filter_ctrl #(
    .MIN_FRAME (MIN_FRAME),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frmStart  (frmStart),
    .byteValid (byteValid),
    .frmEnd    (frmEnd),
    .strb      (strb)
  );

  rx_addr_filter_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .byteData  (byteData),
    .strb      (strb),
    .decValid  (decValid),
    .decAccept (decAccept)
  );

  // R9: decision follows an end strobe by one cycle
  assert_dec_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(frmEnd));

  // R9: accept only together with valid
  assert_acc_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

  localparam int MIN_FRAME = 16;
  localparam int CNT_W     = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [2:0]  cfgSel;
  logic [15:0] cfgWrData;
  logic        frmStart;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        frmEnd;
  logic        decValid;
  logic        decAccept;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit    exp;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  // mirrors of programmed configuration
  logic [47:0] staAddr;
  logic [15:0] filtM, macM, cmdM;

  always #5 clk = ~clk;

  rx_addr_filter #(.MIN_FRAME(MIN_FRAME), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .frmStart(frmStart), .byteValid(byteValid),
    .byteData(byteData), .frmEnd(frmEnd), .decValid(decValid),
    .decAccept(decAccept));

  task automatic cfgWrite(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      3'd0: filtM = data;
      3'd1: macM  = data;
      3'd2: cmdM  = data;
      default: ;
    endcase
  endtask

  // R1: packing of the station address into the three words
  task automatic setStation(input logic [47:0] a);
    staAddr = a;
    cfgWrite(3'd6, {a[39:32], a[47:40]});
    cfgWrite(3'd5, {a[23:16], a[31:24]});
    cfgWrite(3'd4, {a[7:0],   a[15:8]});
  endtask

  function automatic bit model(input logic [47:0] dest, input int len);
    bit rxOn, lenOk, addrOk;
    rxOn   = cmdM[0] && macM[0];
    lenOk  = (len >= MIN_FRAME) || cmdM[6];
    addrOk = macM[1] || ((len >= 6) &&
             ((filtM[1] && dest == 48'hFFFF_FFFF_FFFF) ||
              (filtM[5] && dest == staAddr)));
    return rxOn && lenOk && addrOk;
  endfunction

  task automatic streamBytes(input logic [47:0] dest, input int len);
    @(negedge clk);
    frmStart = 1'b1;
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      byteValid = 1'b1;
      byteData  = (i < 6) ? dest[47 - 8*i -: 8] : 8'(i * 7);
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic sendFrame(input logic [47:0] dest, input int len, input string tag);
    expItem_t it;
    streamBytes(dest, len);
    it.exp = model(dest, len);
    it.tag = tag;
    expQ.push_back(it);
    frmEnd = 1'b1;
    @(negedge clk);
    frmEnd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (decValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected decision, actual accept=%0b expected none", decAccept);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (decAccept !== it.exp) begin
            errors++;
            $display("FAIL %s: accept actual=%0b expected=%0b", it.tag, decAccept, it.exp);
          end
        end
      end else if (decAccept) begin
        checks++;
        errors++;
        $display("FAIL R9: accept without valid, actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgWrData = '0;
    frmStart = 1'b0; byteValid = 1'b0; byteData = '0; frmEnd = 1'b0;
    staAddr = '0; filtM = '0; macM = '0; cmdM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R9 reset state
    if (decValid !== 1'b0 || decAccept !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset outputs actual=%0b%0b expected=00", decValid, decAccept);
    end

    setStation(48'h02_1A_2B_3C_4D_5E);
    cfgWrite(3'd0, 16'h0022);  // broadcast + perfect
    cfgWrite(3'd1, 16'h0001);
    cfgWrite(3'd2, 16'h0001);

    sendFrame(48'h02_1A_2B_3C_4D_5E, 20, "R2");
    sendFrame(48'h02_1A_2B_3C_4D_5F, 20, "R2");
    sendFrame(48'h03_1A_2B_3C_4D_5E, 20, "R1");
    sendFrame(48'h02_1A_2B_3D_4D_5E, 20, "R1");
    sendFrame(48'hFFFF_FFFF_FFFF, 20, "R3");
    cfgWrite(3'd0, 16'h0020);
    sendFrame(48'hFFFF_FFFF_FFFF, 20, "R3");
    cfgWrite(3'd0, 16'h0002);
    sendFrame(48'h02_1A_2B_3C_4D_5E, 20, "R2");
    sendFrame(48'h11_22_33_44_55_66, 20, "R5");
    cfgWrite(3'd0, 16'h0000);
    cfgWrite(3'd1, 16'h0003);  // pass-all
    sendFrame(48'h11_22_33_44_55_66, 20, "R4");
    cfgWrite(3'd1, 16'h0001);
    sendFrame(48'h11_22_33_44_55_66, 20, "R4");
    cfgWrite(3'd0, 16'h0022);

    // R6 runt handling
    sendFrame(48'h02_1A_2B_3C_4D_5E, 10, "R6");
    sendFrame(48'h02_1A_2B_3C_4D_5E, 15, "R6");
    sendFrame(48'h02_1A_2B_3C_4D_5E, 16, "R6");
    cfgWrite(3'd2, 16'h0041);
    sendFrame(48'h02_1A_2B_3C_4D_5E, 10, "R6");
    sendFrame(48'hFFFF_FFFF_FFFF, 4, "R5");
    cfgWrite(3'd2, 16'h0001);

    // R7 receive gating
    cfgWrite(3'd2, 16'h0000);
    sendFrame(48'h02_1A_2B_3C_4D_5E, 20, "R7");
    cfgWrite(3'd2, 16'h0001);
    cfgWrite(3'd1, 16'h0000);
    sendFrame(48'h02_1A_2B_3C_4D_5E, 20, "R7");
    cfgWrite(3'd1, 16'h0001);

    // R8 aborted frame then a fresh one
    streamBytes(48'h02_1A_2B_3C_4D_5E, 3);
    repeat (2) @(negedge clk);
    sendFrame(48'h02_1A_2B_3C_4D_5E, 20, "R8");

    // R10 long frame, counter saturates instead of wrapping
    sendFrame(48'h02_1A_2B_3C_4D_5E, 70, "R10");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9: missing decisions actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule